// File: doc/BRIEF.md
# Inbound window address translator

This block sits between an external expansion-bus master and the on-chip system bus. Each inbound access from the external master carries an address, a read/write flag and byte enables. The block holds one 32-bit configuration word made of an upper base address and a width code. Using the width code, it decides whether the access targets the block's own externally visible register space or should be forwarded to the system bus.

For a forwarded access, it builds the system-bus address by keeping the high bits of the base and filling the rest with the low external address bits. The width code moves the boundary between base bits and external bits, and it also moves the external address bit that selects register space.

The configuration word can be written from the internal side through a simple write port. It can also be rewritten by the external master through register space, unless a lockout input is asserted. All results appear on registered one-cycle strobes, one clock after the access is presented.

Top module: `iwx_inbound_xlate`

## Requirements
- R1: The configuration word reads back with the base in bits 31:21, zeros in bits 20:4 whatever was written there, and the width code in bits 3:0.
- R2: After reset the configuration word reads 0x0000_0008: width code 8 and base 0.
- R3: For width code 8+k (k = 0..3), a forwarded access yields address bits 31:(24-k) from the base and bits (23-k):0 from the external address.
- R4: When external address bit 24-k is 1 under width code 8+k, the access raises `reg_sel_o` with `reg_rdata_o` equal to the configuration word as it was before the access, and raises no forward request.
- R5: With a width code outside 8..11, an access raises `err_o` only, with no forward request, no register select and no change to the configuration.
- R6: While `ext_cfg_lock_i` is 1, external register-space writes leave the configuration unchanged, while external register-space reads still return it.
- R7: While unlocked, an external register-space write replaces the whole configuration word whatever `ext_be_i` holds, including sub-word enables such as 4'b0001.
- R8: When an internal write and an external register-space write occur in the same cycle, the internal data is the value that is kept.
- R9: An access presented in cycle n produces exactly one of `fwd_req_o`, `reg_sel_o` or `err_o` high for cycle n+1 only. A forward request carries `fwd_write_o` equal to `ext_write_i` and `fwd_be_o` equal to `ext_be_i`, and no strobe is raised without an access.
- R10: An internal write with `int_we_i` high in cycle n is visible on `int_rdata_o` from cycle n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_we_i | input | 1 | Internal-side configuration write |
| int_wdata_i | input | 32 | Internal-side write data |
| int_rdata_o | output | 32 | Current configuration word |
| ext_cfg_lock_i | input | 1 | Blocks external configuration writes |
| ext_valid_i | input | 1 | External access present this cycle |
| ext_write_i | input | 1 | External access is a write |
| ext_addr_i | input | 25 | External address |
| ext_be_i | input | 4 | External byte enables |
| ext_wdata_i | input | 32 | External write data |
| fwd_req_o | output | 1 | One-cycle forward request to the system bus |
| fwd_addr_o | output | 32 | Translated system-bus address |
| fwd_write_o | output | 1 | Forwarded access is a write |
| fwd_be_o | output | 4 | Forwarded byte enables |
| reg_sel_o | output | 1 | One-cycle register-space select |
| reg_rdata_o | output | 32 | Configuration word returned for a register-space access |
| err_o | output | 1 | One-cycle reserved-width-code error |

## Verification
The bench aims at the select bit that sits exactly on the boundary for each width code. A design that uses the wrong bit sends register traffic out as forwards or splices one base bit too many or too few into the address. Reserved width codes are mixed into the random traffic, so a design that still forwards or rewrites the configuration under them fails the comparison. The bench also targets locked external writes, sub-word byte enables on register writes, and writes from both sides in the same cycle. A design that merges bytes, ignores the lock or lets the external side win would return a different configuration word on the next read.

// File: rtl/iwx_pkg.sv
package iwx_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned BE_W   = 4;

  typedef enum logic [1:0] {
    XL_NONE = 2'd0,
    XL_FWD  = 2'd1,
    XL_REG  = 2'd2,
    XL_ERR  = 2'd3
  } xl_kind_e;

  typedef struct packed {
    xl_kind_e            kind;
    logic [WORD_W-1:0]   addr;
  } xl_res_t;
endpackage

// File: rtl/iwx_cfg_reg.sv
module iwx_cfg_reg
  import iwx_pkg::*;
#(
  parameter int unsigned BASE_LSB = 21,
  parameter logic [CODE_W-1:0] RST_CODE = 4'h8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              int_we_i,
  input  logic [WORD_W-1:0] int_wdata_i,
  input  logic              ext_we_i,
  input  logic [WORD_W-1:0] ext_wdata_i,
  output logic [WORD_W-1:0] cfg_o,
  output logic [WORD_W-BASE_LSB-1:0] base_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int unsigned BASE_W = WORD_W - BASE_LSB;
  localparam int unsigned RSV_W  = BASE_LSB - CODE_W;

  logic [BASE_W-1:0] base_q;
  logic [CODE_W-1:0] code_q;
  logic [WORD_W-1:0] wsel;

  // internal side wins a same-cycle collision
  assign wsel = int_we_i ? int_wdata_i : ext_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      code_q <= RST_CODE;
    end else if (int_we_i || ext_we_i) begin
      base_q <= wsel[WORD_W-1:BASE_LSB];
      code_q <= wsel[CODE_W-1:0];
    end
  end

  logic unused_rsv;
  assign unused_rsv = ^wsel[BASE_LSB-1:CODE_W];

  assign cfg_o  = {base_q, {RSV_W{1'b0}}, code_q};
  assign base_o = base_q;
  assign code_o = code_q;
endmodule

// File: rtl/iwx_decode.sv
module iwx_decode
  import iwx_pkg::*;
#(
  parameter int unsigned ADDR_W    = 25,
  parameter int unsigned BASE_LSB  = 21,
  parameter int unsigned CODE_MIN  = 8,
  parameter int unsigned NUM_CODES = 4
) (
  input  logic                        valid_i,
  input  logic [WORD_W-BASE_LSB-1:0]  base_i,
  input  logic [CODE_W-1:0]           code_i,
  input  logic [ADDR_W-1:0]           addr_i,
  output xl_res_t                     res_o
);
  localparam int unsigned SEL_TOP = ADDR_W - 1;

  logic [NUM_CODES-1:0] hit;
  logic [NUM_CODES-1:0] sel_v;
  logic [WORD_W-1:0]    addr_v [NUM_CODES];

  for (genvar gi = 0; gi < NUM_CODES; gi++) begin : g_code
    localparam int unsigned SB = SEL_TOP - gi;
    assign hit[gi]    = (code_i == CODE_W'(CODE_MIN + gi));
    assign sel_v[gi]  = addr_i[SB];
    assign addr_v[gi] = {base_i[WORD_W-BASE_LSB-1:SB-BASE_LSB], addr_i[SB-1:0]};
  end

  logic              any_hit;
  logic              sel;
  logic [WORD_W-1:0] addr;

  always_comb begin
    any_hit = 1'b0;
    sel     = 1'b0;
    addr    = '0;
    for (int i = 0; i < NUM_CODES; i++) begin
      if (hit[i]) begin
        any_hit = 1'b1;
        sel     = sel_v[i];
        addr    = addr_v[i];
      end
    end
  end

  always_comb begin
    res_o.addr = addr;
    if (!valid_i)      res_o.kind = XL_NONE;
    else if (!any_hit) res_o.kind = XL_ERR;
    else if (sel)      res_o.kind = XL_REG;
    else               res_o.kind = XL_FWD;
  end
endmodule

// File: rtl/iwx_resp.sv
module iwx_resp
  import iwx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  xl_res_t           res_i,
  input  logic              write_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [WORD_W-1:0] cfg_i,
  output logic              fwd_req_o,
  output logic [WORD_W-1:0] fwd_addr_o,
  output logic              fwd_write_o,
  output logic [BE_W-1:0]   fwd_be_o,
  output logic              reg_sel_o,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic              err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_req_o   <= 1'b0;
      reg_sel_o   <= 1'b0;
      err_o       <= 1'b0;
      fwd_addr_o  <= '0;
      fwd_write_o <= 1'b0;
      fwd_be_o    <= '0;
      reg_rdata_o <= '0;
    end else begin
      fwd_req_o <= (res_i.kind == XL_FWD);
      reg_sel_o <= (res_i.kind == XL_REG);
      err_o     <= (res_i.kind == XL_ERR);
      if (res_i.kind == XL_FWD) begin
        fwd_addr_o  <= res_i.addr;
        fwd_write_o <= write_i;
        fwd_be_o    <= be_i;
      end
      if (res_i.kind == XL_REG) reg_rdata_o <= cfg_i;
    end
  end
endmodule

// File: rtl/iwx_inbound_xlate.sv
module iwx_inbound_xlate
  import iwx_pkg::*;
#(
  parameter int unsigned ADDR_W    = 25,
  parameter int unsigned BASE_LSB  = 21,
  parameter int unsigned CODE_MIN  = 8,
  parameter int unsigned NUM_CODES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              int_we_i,
  input  logic [31:0]       int_wdata_i,
  output logic [31:0]       int_rdata_o,
  input  logic              ext_cfg_lock_i,
  input  logic              ext_valid_i,
  input  logic              ext_write_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  input  logic [3:0]        ext_be_i,
  input  logic [31:0]       ext_wdata_i,
  output logic              fwd_req_o,
  output logic [31:0]       fwd_addr_o,
  output logic              fwd_write_o,
  output logic [3:0]        fwd_be_o,
  output logic              reg_sel_o,
  output logic [31:0]       reg_rdata_o,
  output logic              err_o
);
  localparam int unsigned BASE_W = WORD_W - BASE_LSB;

  logic [WORD_W-1:0] cfg;
  logic [BASE_W-1:0] base;
  logic [CODE_W-1:0] code;
  xl_res_t           res;
  logic              ext_we;

  // byte enables never narrow a config write
  assign ext_we = (res.kind == XL_REG) && ext_write_i && !ext_cfg_lock_i;

  iwx_cfg_reg #(
    .BASE_LSB (BASE_LSB),
    .RST_CODE (CODE_W'(CODE_MIN))
  ) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .int_we_i    (int_we_i),
    .int_wdata_i (int_wdata_i),
    .ext_we_i    (ext_we),
    .ext_wdata_i (ext_wdata_i),
    .cfg_o       (cfg),
    .base_o      (base),
    .code_o      (code)
  );

  iwx_decode #(
    .ADDR_W    (ADDR_W),
    .BASE_LSB  (BASE_LSB),
    .CODE_MIN  (CODE_MIN),
    .NUM_CODES (NUM_CODES)
  ) u_dec (
    .valid_i (ext_valid_i),
    .base_i  (base),
    .code_i  (code),
    .addr_i  (ext_addr_i),
    .res_o   (res)
  );

  iwx_resp u_resp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .res_i       (res),
    .write_i     (ext_write_i),
    .be_i        (ext_be_i),
    .cfg_i       (cfg),
    .fwd_req_o   (fwd_req_o),
    .fwd_addr_o  (fwd_addr_o),
    .fwd_write_o (fwd_write_o),
    .fwd_be_o    (fwd_be_o),
    .reg_sel_o   (reg_sel_o),
    .reg_rdata_o (reg_rdata_o),
    .err_o       (err_o)
  );

  assign int_rdata_o = cfg;
endmodule

// File: rtl/iwx_inbound_xlate_chk.sv
module iwx_inbound_xlate_chk #(
  parameter int unsigned ADDR_W = 25
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              int_we_i,
  input logic [31:0]       int_wdata_i,
  input logic [31:0]       int_rdata_o,
  input logic              ext_cfg_lock_i,
  input logic              ext_valid_i,
  input logic              ext_write_i,
  input logic [ADDR_W-1:0] ext_addr_i,
  input logic [3:0]        ext_be_i,
  input logic              fwd_req_o,
  input logic [31:0]       fwd_addr_o,
  input logic              fwd_write_o,
  input logic [3:0]        fwd_be_o,
  input logic              reg_sel_o,
  input logic              err_o
);
  a_r1_rsv_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_rdata_o[20:4] == '0);

  a_r9_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fwd_req_o, reg_sel_o, err_o}));

  a_r9_no_access_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_valid_i |=> !(fwd_req_o || reg_sel_o || err_o));

  a_r9_fwd_attrs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_valid_i |=> (fwd_req_o -> (fwd_write_o == $past(ext_write_i) && fwd_be_o == $past(ext_be_i))));

  a_r3_fwd_top_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_valid_i |=> (fwd_req_o -> fwd_addr_o[31:24] == $past(int_rdata_o[31:24])));

  a_r6_lock_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_cfg_lock_i && !int_we_i) |=> $stable(int_rdata_o));

  a_r10_int_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_we_i |=> int_rdata_o == ($past(int_wdata_i) & 32'hFFE0_000F));
endmodule

bind iwx_inbound_xlate iwx_inbound_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .int_we_i       (int_we_i),
  .int_wdata_i    (int_wdata_i),
  .int_rdata_o    (int_rdata_o),
  .ext_cfg_lock_i (ext_cfg_lock_i),
  .ext_valid_i    (ext_valid_i),
  .ext_write_i    (ext_write_i),
  .ext_addr_i     (ext_addr_i),
  .ext_be_i       (ext_be_i),
  .fwd_req_o      (fwd_req_o),
  .fwd_addr_o     (fwd_addr_o),
  .fwd_write_o    (fwd_write_o),
  .fwd_be_o       (fwd_be_o),
  .reg_sel_o      (reg_sel_o),
  .err_o          (err_o)
);

// File: tb/iwx_inbound_xlate_tb.sv
module iwx_inbound_xlate_tb;
  localparam logic [31:0] MASK = 32'hFFE0_000F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        int_we = 0;
  logic [31:0] int_wdata = 0;
  logic [31:0] int_rdata;
  logic        lock = 0;
  logic        ev = 0, ew = 0;
  logic [24:0] ea = 0;
  logic [3:0]  ebe = 0;
  logic [31:0] ewd = 0;
  logic        fwd_req, fwd_write, reg_sel, err;
  logic [31:0] fwd_addr, reg_rdata;
  logic [3:0]  fwd_be;

  iwx_inbound_xlate u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .int_we_i(int_we), .int_wdata_i(int_wdata), .int_rdata_o(int_rdata),
    .ext_cfg_lock_i(lock), .ext_valid_i(ev), .ext_write_i(ew),
    .ext_addr_i(ea), .ext_be_i(ebe), .ext_wdata_i(ewd),
    .fwd_req_o(fwd_req), .fwd_addr_o(fwd_addr), .fwd_write_o(fwd_write),
    .fwd_be_o(fwd_be), .reg_sel_o(reg_sel), .reg_rdata_o(reg_rdata), .err_o(err)
  );

  int unsigned n_vec = 0, n_bad = 0;
  logic [31:0] m_cfg;
  logic x_fwd = 0, x_reg = 0, x_err = 0, x_w = 0;
  logic [31:0] x_addr = 0, x_rd = 0;
  logic [3:0]  x_be = 0;
  string x_tag = "R9";

  function automatic logic [31:0] xlate(logic [31:0] cfg, logic [24:0] a);
    int unsigned sb = 24 - (cfg[3:0] - 8);
    logic [31:0] lo = (32'd1 << sb) - 1;
    return ({cfg[31:21], 21'd0} & ~lo) | ({7'd0, a} & lo);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic v, logic w, logic [24:0] a, logic [3:0] be,
                       logic [31:0] wd, logic lk, logic iwe, logic [31:0] iwd,
                       string tag);
    logic ok;
    logic sel;
    @(negedge clk);
    chk("R10 int_rdata", int_rdata, m_cfg);
    chk({x_tag, " fwd_req"}, {31'd0, fwd_req}, {31'd0, x_fwd});
    chk({x_tag, " reg_sel"}, {31'd0, reg_sel}, {31'd0, x_reg});
    chk("R5 err", {31'd0, err}, {31'd0, x_err});
    if (x_fwd) begin
      chk("R3 fwd_addr", fwd_addr, x_addr);
      chk("R9 fwd_write/be", {27'd0, fwd_write, fwd_be}, {27'd0, x_w, x_be});
    end
    if (x_reg) chk("R4 reg_rdata", reg_rdata, x_rd);
    ev = v; ew = w; ea = a; ebe = be; ewd = wd; lock = lk;
    int_we = iwe; int_wdata = iwd;
    ok  = (m_cfg[3:0] >= 4'h8) && (m_cfg[3:0] <= 4'hB);
    sel = ok ? a[24 - (m_cfg[3:0] - 8)] : 1'b0;
    x_tag = tag;
    x_err = v && !ok;
    x_reg = v && ok && sel;
    x_fwd = v && ok && !sel;
    x_addr = ok ? xlate(m_cfg, a) : 32'd0;
    x_w = w; x_be = be; x_rd = m_cfg;
    if (iwe) m_cfg = iwd & MASK;
    else if (x_reg && w && !lk) m_cfg = wd & MASK;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] cw;
    void'($urandom(32'h5EED_1234));
    m_cfg = 32'h0000_0008;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R2 reset value, checked on first apply
    apply(0, 0, 0, 0, 0, 0, 0, 0, "R2");
    chk("R2 reset cfg", int_rdata, 32'h0000_0008);
    // R1 reserved bits dropped on internal write
    apply(0, 0, 0, 0, 0, 0, 1, 32'hABCD_EF09, "R1");
    apply(0, 0, 0, 0, 0, 0, 0, 0, "R1");
    chk("R1 layout", int_rdata, 32'hABC0_0009);
    // R3/R4 boundary bit per code
    for (int k = 0; k < 4; k++) begin
      apply(0, 0, 0, 0, 0, 0, 1, 32'hFFE0_0000 | (8 + k), "R3");
      apply(1, 0, 25'h1FF_FFFF & ~(25'd1 << (24 - k)), 4'hF, 0, 0, 0, 0, "R3");
      apply(1, 1, 25'd1 << (24 - k), 4'h3, 0, 1, 0, 0, "R4");
    end
    // R5 reserved code
    apply(0, 0, 0, 0, 0, 0, 1, 32'h1230_0003, "R5");
    apply(1, 1, 25'h1FF_FFFF, 4'hF, 32'h0000_0008, 0, 0, 0, "R5");
    apply(1, 0, 25'h0, 4'hF, 0, 0, 0, 0, "R5");
    apply(0, 0, 0, 0, 0, 0, 1, 32'h0000_0008, "R5");
    // R6 locked write ignored, read still works
    apply(1, 1, 25'h100_0000, 4'hF, 32'h5550_000A, 1, 0, 0, "R6");
    apply(1, 0, 25'h100_0000, 4'hF, 0, 1, 0, 0, "R6");
    // R7 sub-word enables still write full word
    apply(1, 1, 25'h100_0004, 4'b0001, 32'h8860_000B, 0, 0, 0, "R7");
    apply(0, 0, 0, 0, 0, 0, 0, 0, "R7");
    chk("R7 full word", int_rdata, 32'h8860_000B);
    // R8 simultaneous writes
    apply(1, 1, 25'h020_0000, 4'hF, 32'h1110_0009, 0, 1, 32'h2220_000A, "R8");
    apply(0, 0, 0, 0, 0, 0, 0, 0, "R8");
    chk("R8 internal wins", int_rdata, 32'h2220_000A);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      cw = $urandom;
      cw[3:0] = ($urandom % 5 == 0) ? 4'($urandom) : 4'(8 + $urandom % 4);
      apply($urandom % 4 != 0, $urandom % 2 == 1, 25'($urandom), 4'($urandom),
            cw, $urandom % 3 == 0, $urandom % 8 == 0, cw, "R9");
      if ((m_cfg[3:0] < 8 || m_cfg[3:0] > 11) && $urandom % 2 == 0)
        apply(0, 0, 0, 0, 0, 0, 1, {11'($urandom), 17'd0, 4'(8 + $urandom % 4)}, "R5");
    end
    apply(0, 0, 0, 0, 0, 0, 0, 0, "R9");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule